// File: doc/BRIEF.md
# Edge-Qualified Timestamp Capture for Two Pins

This block gives two general-purpose pins the ability to freeze the chip's running time-of-day value. Each pin passes through a synchronizer and then a width qualifier; once the pin has sat at its active level long enough, the block copies the 64-bit time input into that pin's own pair of 32-bit capture registers. Both halves are loaded on the same clock edge.

A qualified event raises two sticky flags for its pin. One is a general pin-interrupt flag and the other is a timestamp flag. Software clears each flag by writing a one to it. Each pin can also be set up so that its event clears a separate clock-target interrupt flag. That flag is set by a compare pulse from the time unit outside this block. The time counter, the bus decode and the pad drivers all sit outside.

Top module: `gts_capture`

## Requirements
- R1: After reset every capture register reads zero and all flags (per-pin general flags, per-pin timestamp flags, target flag) are low.
- R2: A pin counts as active only after its synchronized level has held the active value for QUAL_CYCLES (default 5) consecutive clocks. An active phase of QUAL_CYCLES-1 clocks produces no event. An active phase of exactly QUAL_CYCLES clocks produces one event.
- R3: An event needs a transition. A level that is already active when reset ends causes no event. A level held active for any length of time produces exactly one event. The pin must return to inactive before another event can occur.
- R4: The polarity bit cfg_rise_i[i] selects the active level. A 1 makes a high level (rising edge) active, and a 0 makes a low level (falling edge) active.
- R5: On an event, cap_hi_o[i] takes time_i[63:32] and cap_lo_o[i] takes time_i[31:0], both on the same edge. The value is the one present at the clock edge that is the (SYNC_STAGES+QUAL_CYCLES)-th edge to see the pin active, counting the first such edge as 1. Without an event, the capture registers hold their value.
- R6: Each pin has its own capture registers and flags. An event on one pin leaves the other pin's registers and flags unchanged.
- R7: An event on pin i sets both gpio_flag_o[i] and ts_flag_o[i] on the edge that loads the capture.
- R8: A one on gpio_clr_i[i] or ts_clr_i[i] clears the matching flag on the next edge. If an event on that pin lands on the same edge, the flag ends up set.
- R9: tgt_flag_o is set by tgt_set_i and cleared by tgt_clr_i. It is also cleared by an event on any pin whose cfg_tclr_en_i bit is 1. tgt_set_i takes priority over every clear. With the enable bit at 0, a pin event leaves tgt_flag_o unchanged.
- R10: When cfg_in_i[i] is 0 (pin used as an output), a qualified edge on that pin loads no capture, sets no flag and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 ns nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Raw pin levels, asynchronous |
| time_i | input | 64 | Running time-of-day value |
| cfg_rise_i | input | NPIN | Per-pin polarity: 1 rising/high, 0 falling/low |
| cfg_in_i | input | NPIN | Per-pin input mode; capture only when 1 |
| cfg_tclr_en_i | input | NPIN | Per-pin enable for clearing the target flag |
| tgt_set_i | input | 1 | Target compare pulse that sets the target flag |
| tgt_clr_i | input | 1 | Write-one-to-clear for the target flag |
| gpio_clr_i | input | NPIN | Write-one-to-clear for the general pin flags |
| ts_clr_i | input | NPIN | Write-one-to-clear for the timestamp flags |
| cap_hi_o | output | NPIN x 32 | Captured upper time words |
| cap_lo_o | output | NPIN x 32 | Captured lower time words |
| gpio_flag_o | output | NPIN | General pin interrupt flags |
| ts_flag_o | output | NPIN | Timestamp interrupt flags |
| tgt_flag_o | output | 1 | Clock-target interrupt flag |

## Verification
The bench sends pulses one clock shorter than the qualifier and pulses exactly as long as it. A qualifier that is off by one would either drop the event or let the short glitch through. A pin held high for a long stretch tests whether the design fires again while the level persists. Flipping the polarity with the pin idle high tests whether the design still treats a rising edge as active. A clear pulse placed on the exact edge of an event tests priority, and a design that lets the clear win would lose the interrupt. Further cases toggle the target-clear enable and disable input mode; a wrong design would clear the target flag with the enable off, or capture while the pin is an output.

// File: rtl/gts_pkg.sv
package gts_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned TIME_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } stamp_t;
endpackage

// File: rtl/gts_sync.sv
module gts_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [STAGES-1:0][N-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            sh_d[s] = sh_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gts_qual.sv
module gts_qual #(
    parameter int unsigned QUAL = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic pol_i,
    output logic ev_o
);
    localparam int unsigned CW = $clog2(QUAL + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;
    logic act;
    logic ev;

    always_comb begin
        act  = (lvl_i == pol_i);
        ev   = st_q.armed && act && (st_q.cnt == CW'(QUAL - 1));
        st_d = st_q;
        if (!act) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (ev) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_o = ev;

    // One event per active phase
    assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o |=> !ev_o);

    // An inactive cycle restarts the width count
    assert_width_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((QUAL > 1) && !act) |=> !ev_o);
endmodule

// File: rtl/gts_capture.sv
module gts_capture
    import gts_pkg::*;
#(
    parameter int unsigned NPIN        = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYCLES = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPIN-1:0]              pin_i,
    input  logic [TIME_W-1:0]            time_i,
    input  logic [NPIN-1:0]              cfg_rise_i,
    input  logic [NPIN-1:0]              cfg_in_i,
    input  logic [NPIN-1:0]              cfg_tclr_en_i,
    input  logic                         tgt_set_i,
    input  logic                         tgt_clr_i,
    input  logic [NPIN-1:0]              gpio_clr_i,
    input  logic [NPIN-1:0]              ts_clr_i,
    output logic [NPIN-1:0][WORD_W-1:0]  cap_hi_o,
    output logic [NPIN-1:0][WORD_W-1:0]  cap_lo_o,
    output logic [NPIN-1:0]              gpio_flag_o,
    output logic [NPIN-1:0]              ts_flag_o,
    output logic                         tgt_flag_o
);
    typedef struct packed {
        stamp_t [NPIN-1:0] cap;
        logic   [NPIN-1:0] gflag;
        logic   [NPIN-1:0] tflag;
        logic              tgt;
    } cst_t;

    cst_t            st_d, st_q;
    logic [NPIN-1:0] lvl;
    logic [NPIN-1:0] ev;
    logic [NPIN-1:0] hit;

    gts_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (lvl)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_qual
        gts_qual #(.QUAL(QUAL_CYCLES)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl[g]),
            .pol_i (cfg_rise_i[g]),
            .ev_o  (ev[g])
        );
    end

    always_comb begin
        hit   = ev & cfg_in_i;
        st_d  = st_q;
        for (int i = 0; i < NPIN; i++) begin
            if (hit[i]) begin
                st_d.cap[i].hi = time_i[TIME_W-1:WORD_W];
                st_d.cap[i].lo = time_i[WORD_W-1:0];
            end
        end
        st_d.gflag = (st_q.gflag & ~gpio_clr_i) | hit;
        st_d.tflag = (st_q.tflag & ~ts_clr_i) | hit;
        st_d.tgt   = tgt_set_i
                   | (st_q.tgt & ~tgt_clr_i & ~(|(hit & cfg_tclr_en_i)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            cap_hi_o[i] = st_q.cap[i].hi;
            cap_lo_o[i] = st_q.cap[i].lo;
        end
    end

    assign gpio_flag_o = st_q.gflag;
    assign ts_flag_o   = st_q.tflag;
    assign tgt_flag_o  = st_q.tgt;

    for (genvar a = 0; a < NPIN; a++) begin : g_chk
        assert_stamp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[a] |=> ($stable(cap_hi_o[a]) && $stable(cap_lo_o[a])));

        assert_stamp_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hit[a] |=> (cap_lo_o[a] == $past(time_i[WORD_W-1:0]))
                    && (cap_hi_o[a] == $past(time_i[TIME_W-1:WORD_W])));

        assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[a] |=> (gpio_flag_o[a] && ts_flag_o[a]));

        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (gpio_clr_i[a] && !hit[a]) |=> !gpio_flag_o[a]);

        assert_tgt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[a] && cfg_tclr_en_i[a] && !tgt_set_i) |=> !tgt_flag_o);

        assert_output_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_in_i[a] && ts_clr_i[a]) |=> !ts_flag_o[a]);
    end
endmodule

// File: tb/gts_capture_test.sv
module gts_capture_test;
    localparam int CLK_NS = 10;
    localparam int NPIN   = 2;
    localparam int SYNC   = 2;
    localparam int QUAL   = 5;
    localparam int WW     = 32;

    logic                      clk;
    logic                      rst_n;
    logic [NPIN-1:0]           pin_i;
    logic [63:0]               time_i;
    logic [NPIN-1:0]           cfg_rise_i, cfg_in_i, cfg_tclr_en_i;
    logic                      tgt_set_i, tgt_clr_i;
    logic [NPIN-1:0]           gpio_clr_i, ts_clr_i;
    logic [NPIN-1:0][WW-1:0]   cap_hi_o, cap_lo_o;
    logic [NPIN-1:0]           gpio_flag_o, ts_flag_o;
    logic                      tgt_flag_o;

    int checks = 0;
    int fails  = 0;

    gts_capture #(.NPIN(NPIN), .SYNC_STAGES(SYNC), .QUAL_CYCLES(QUAL)) uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .time_i(time_i),
        .cfg_rise_i(cfg_rise_i), .cfg_in_i(cfg_in_i), .cfg_tclr_en_i(cfg_tclr_en_i),
        .tgt_set_i(tgt_set_i), .tgt_clr_i(tgt_clr_i),
        .gpio_clr_i(gpio_clr_i), .ts_clr_i(ts_clr_i),
        .cap_hi_o(cap_hi_o), .cap_lo_o(cap_lo_o),
        .gpio_flag_o(gpio_flag_o), .ts_flag_o(ts_flag_o), .tgt_flag_o(tgt_flag_o)
    );

    initial clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    initial time_i = 64'hA5A5_0000_0000_0010;
    always @(negedge clk) time_i = time_i + 64'h0000_0001_0000_0003;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: delay queues for the synchronizer, integers for the width count
    bit          dq[NPIN][$];
    int          run[NPIN];
    bit          ready[NPIN];
    logic [63:0] m_cap[NPIN];
    bit          m_g[NPIN], m_t[NPIN], m_tgt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIN; i++) begin
                dq[i] = {};
                for (int s = 0; s < SYNC; s++) dq[i].push_back(1'b0);
                run[i] = 0; ready[i] = 0; m_cap[i] = '0; m_g[i] = 0; m_t[i] = 0;
            end
            m_tgt = 0;
        end else begin
            bit any_tclr;
            any_tclr = 0;
            for (int i = 0; i < NPIN; i++) begin
                bit seen, active, fired, take;
                seen   = dq[i][0];
                active = (seen == cfg_rise_i[i]);
                fired  = ready[i] && active && (run[i] == QUAL - 1);
                take   = fired && cfg_in_i[i];
                if (!active) begin ready[i] = 1; run[i] = 0; end
                else if (fired) begin ready[i] = 0; run[i] = 0; end
                else if (ready[i]) run[i] = run[i] + 1;
                if (take) begin
                    m_cap[i] = time_i;
                    m_g[i] = 1; m_t[i] = 1;
                    if (cfg_tclr_en_i[i]) any_tclr = 1;
                end else begin
                    if (gpio_clr_i[i]) m_g[i] = 0;
                    if (ts_clr_i[i])   m_t[i] = 0;
                end
                void'(dq[i].pop_front());
                dq[i].push_back(pin_i[i]);
            end
            if (tgt_set_i) m_tgt = 1;
            else if (tgt_clr_i || any_tclr) m_tgt = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NPIN; i++) begin
                chk({32'h0, cap_hi_o[i]}, {32'h0, m_cap[i][63:32]}, "R5 cap_hi model");
                chk({32'h0, cap_lo_o[i]}, {32'h0, m_cap[i][31:0]},  "R5 cap_lo model");
                chk({63'h0, gpio_flag_o[i]}, {63'h0, m_g[i]}, "R7 gpio flag model");
                chk({63'h0, ts_flag_o[i]},   {63'h0, m_t[i]}, "R7 ts flag model");
            end
            chk({63'h0, tgt_flag_o}, {63'h0, m_tgt}, "R9 target flag model");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int i, input bit lvl, input int n);
        pin_i[i] = lvl;
        tick(n);
        pin_i[i] = ~lvl;
        tick(10);
    endtask

    task automatic clear_all();
        gpio_clr_i = '1; ts_clr_i = '1;
        tick(1);
        gpio_clr_i = '0; ts_clr_i = '0;
        tick(1);
    endtask

    initial begin
        #(CLK_NS * 50000);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [WW-1:0] saved;
        rst_n = 0; pin_i = '0; cfg_rise_i = '1; cfg_in_i = '1; cfg_tclr_en_i = '0;
        tgt_set_i = 0; tgt_clr_i = 0; gpio_clr_i = '0; ts_clr_i = '0;
        tick(3);
        rst_n = 1;
        tick(1);
        // R1: reset state
        chk({cap_hi_o[0], cap_lo_o[0]}, 64'h0, "R1 cap pin0");
        chk({cap_hi_o[1], cap_lo_o[1]}, 64'h0, "R1 cap pin1");
        chk({59'h0, gpio_flag_o, ts_flag_o, tgt_flag_o}, 64'h0, "R1 flags");
        tick(3);

        // R7 / R6: rising pulse on pin 0
        pulse(0, 1'b1, 8);
        chk({63'h0, gpio_flag_o[0]}, 64'h1, "R7 gpio flag pin0");
        chk({63'h0, ts_flag_o[0]},   64'h1, "R7 ts flag pin0");
        chk({32'h0, cap_hi_o[1]}, 64'h0, "R6 pin1 cap untouched");
        chk({63'h0, gpio_flag_o[1]}, 64'h0, "R6 pin1 flag untouched");

        // R8: write-one-to-clear
        clear_all();
        chk({62'h0, gpio_flag_o}, 64'h0, "R8 gpio flags cleared");
        chk({62'h0, ts_flag_o},   64'h0, "R8 ts flags cleared");

        // R2: width boundary
        pulse(1, 1'b1, QUAL - 1);
        chk({63'h0, gpio_flag_o[1]}, 64'h0, "R2 short pulse ignored");
        pulse(1, 1'b1, QUAL);
        chk({63'h0, gpio_flag_o[1]}, 64'h1, "R2 exact width accepted");
        clear_all();

        // R3: long level fires once
        pin_i[0] = 1'b1;
        tick(20);
        chk({63'h0, gpio_flag_o[0]}, 64'h1, "R3 held level fires");
        clear_all();
        tick(20);
        chk({63'h0, gpio_flag_o[0]}, 64'h0, "R3 no refire while held");
        pin_i[0] = 1'b0;
        tick(10);

        // R4: falling polarity on pin 1
        pin_i[1] = 1'b1; cfg_rise_i[1] = 1'b0;
        tick(15);
        clear_all();
        tick(2);
        pulse(1, 1'b0, 8);
        chk({63'h0, gpio_flag_o[1]}, 64'h1, "R4 falling edge fires");
        clear_all();
        tick(10);
        chk({63'h0, gpio_flag_o[1]}, 64'h0, "R4 rising ignored when falling set");
        pin_i[1] = 1'b0;
        tick(12);
        cfg_rise_i[1] = 1'b1;
        tick(3);
        clear_all();

        // R8: event and clear on the same edge
        pin_i[0] = 1'b1;
        tick(SYNC + QUAL - 1);
        gpio_clr_i[0] = 1'b1;
        tick(1);
        gpio_clr_i[0] = 1'b0;
        chk({63'h0, gpio_flag_o[0]}, 64'h1, "R8 event beats clear");
        pin_i[0] = 1'b0;
        tick(10);
        clear_all();

        // R9: target flag
        tgt_set_i = 1; tick(1); tgt_set_i = 0;
        chk({63'h0, tgt_flag_o}, 64'h1, "R9 target set");
        pulse(0, 1'b1, 8);
        chk({63'h0, tgt_flag_o}, 64'h1, "R9 no clear without enable");
        cfg_tclr_en_i[0] = 1'b1;
        pulse(0, 1'b1, 8);
        chk({63'h0, tgt_flag_o}, 64'h0, "R9 pin event clears target");
        tgt_set_i = 1; tick(1); tgt_set_i = 0;
        tgt_clr_i = 1; tick(1); tgt_clr_i = 0;
        chk({63'h0, tgt_flag_o}, 64'h0, "R9 target w1c");
        tgt_set_i = 1; tick(1); tgt_set_i = 0;
        clear_all();

        // R10: output mode blocks capture and target clear
        cfg_in_i[0] = 1'b0;
        saved = cap_lo_o[0];
        pulse(0, 1'b1, 8);
        chk({63'h0, gpio_flag_o[0]}, 64'h0, "R10 no flag in output mode");
        chk({32'h0, cap_lo_o[0]}, {32'h0, saved}, "R10 cap held in output mode");
        chk({63'h0, tgt_flag_o}, 64'h1, "R10 target kept in output mode");
        cfg_in_i[0] = 1'b1;
        tick(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule